// File: doc/BRIEF.md
# Bus Hold Handshake Controller

This block runs the handshake through which the chip lends its external bus to another master and later takes it back. A second master asks for the bus by pulling an active-low hold request low. When the hold protocol is enabled, the controller waits for a bus-idle boundary. It then grants the hold by asserting an active-low acknowledge. In the same cycle it tells the bus drivers to float.

While the bus is lent out, the chip may need an external memory cycle of its own. In that case the controller asserts an active-low bus request toward the holding master. The bus request never comes before the acknowledge. Once it is raised, it stays raised until the other master withdraws its hold request.

The hold request comes from outside the chip's clock domain, so a synchroniser chain samples it before use. After the hold is withdrawn, the acknowledge and the bus request clear together. The drivers stay floated for one more cycle so that the two masters never drive the bus at the same time. All pins are plain level controls; the block has no data path and no valid/ready interface.

Top module: `bus_hold_ctrl`

## Requirements
- R1: While reset is asserted and right after it, hold_ack_n and bus_req_n are 1 and bus_float is 0.
- R2: hold_req_n passes through SYNC_STAGES flops (default 2) before it is acted on. With bus_idle high, hold_ack_n falls no earlier than the fourth rising edge after hold_req_n falls: two synchroniser edges, one edge into the granting phase, and one edge into the held phase.
- R3: While hold_en is 0, a low hold_req_n has no effect: hold_ack_n and bus_req_n stay 1 and bus_float stays 0.
- R4: The grant happens only on an edge where bus_idle is 1 and the synchronised request is active. hold_ack_n falls and bus_float rises on the same edge.
- R5: bus_req_n is 0 only while hold_ack_n is 0. It can fall in the same cycle as hold_ack_n, but never before it.
- R6: While held, bus_req_n falls only when cyc_pending is 1. If cyc_pending is already 1 when the hold is granted, bus_req_n falls together with hold_ack_n.
- R7: Once bus_req_n is 0, it stays 0 while the synchronised hold request and hold_en remain active, even if cyc_pending drops.
- R8: When the synchronised hold request goes inactive in the held phase, hold_ack_n and bus_req_n return to 1 on the same edge. bus_float stays 1 for exactly one further cycle.
- R9: If hold_en drops while held, the block leaves the held phase exactly as in R8.
- R10: If the hold request is withdrawn, or hold_en drops, before a bus-idle boundary is reached, the block returns to released without ever asserting hold_ack_n or floating the bus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_req_n | input | 1 | Active-low hold request from the other master, asynchronous |
| hold_en | input | 1 | Enables the hold protocol |
| bus_idle | input | 1 | High on cycles where the bus may change hands |
| cyc_pending | input | 1 | An external memory cycle of the chip is waiting |
| hold_ack_n | output | 1 | Active-low hold acknowledge |
| bus_req_n | output | 1 | Active-low bus request toward the holding master |
| bus_float | output | 1 | High tells the bus drivers to release the bus |

## Verification
The bench targets the ordering corners. It raises cyc_pending before the grant and checks that bus_req_n falls exactly with hold_ack_n; a design that ran one cycle late would miss this, and one that ran early would assert the request before the acknowledge. It pulses cyc_pending for one cycle while held; a design without the latch would release bus_req_n early. It withdraws the hold both before and after the idle boundary, and it drops hold_en in the middle of a hold. A wrong design would then either grant late, keep driving during the overlap cycle, or leave the bus floated. It also checks the grant latency against the two-flop synchroniser; a missing stage or an extra stage shifts every acknowledge by a cycle.

// File: rtl/bhh_pkg.sv
package bhh_pkg;

  typedef enum logic [1:0] {
    PH_RELEASED = 2'd0,
    PH_GRANTING = 2'd1,
    PH_HELD     = 2'd2,
    PH_RECOVER  = 2'd3
  } bhh_phase_e;

  localparam int BHH_SYNC_DEFAULT = 2;

  function automatic logic phase_floats(bhh_phase_e ph);
    return (ph == PH_HELD) || (ph == PH_RECOVER);
  endfunction

endpackage

// File: rtl/bhh_sync.sv
module bhh_sync #(
  parameter int STAGES    = 2,
  parameter bit RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);

  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain;

  generate
    genvar gi;
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= RESET_VAL;
          else        chain[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[gi] <= RESET_VAL;
          else        chain[gi] <= chain[gi-1];
        end
      end
    end
  endgenerate

  assign sync_out = chain[LAST];

endmodule

// File: rtl/bhh_fsm.sv
module bhh_fsm
  import bhh_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hold_seen,
  input  logic hold_en,
  input  logic bus_idle,
  output logic in_held,
  output logic stay_held,
  output logic float_o
);

  bhh_phase_e phase_q, phase_d;
  logic       keep_hold;

  assign keep_hold = hold_seen && hold_en;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_RELEASED: if (keep_hold) phase_d = PH_GRANTING;
      PH_GRANTING: begin
        if (!keep_hold)    phase_d = PH_RELEASED;
        else if (bus_idle) phase_d = PH_HELD;
      end
      PH_HELD:     if (!keep_hold) phase_d = PH_RECOVER;
      PH_RECOVER:  phase_d = PH_RELEASED;
      default:     phase_d = PH_RELEASED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_RELEASED;
    else        phase_q <= phase_d;
  end

  assign in_held   = (phase_q == PH_HELD);
  assign stay_held = in_held && (phase_d == PH_HELD);
  assign float_o   = phase_floats(phase_q);

endmodule

// File: rtl/bhh_req_latch.sv
module bhh_req_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic in_held,
  input  logic stay_held,
  input  logic cyc_pending,
  output logic req_active
);

  logic seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         seen_q <= 1'b0;
    else if (stay_held) seen_q <= seen_q | cyc_pending;
    else                seen_q <= 1'b0;
  end

  assign req_active = in_held && (seen_q || cyc_pending);

endmodule

// File: rtl/bus_hold_ctrl.sv
module bus_hold_ctrl
  import bhh_pkg::*;
#(
  parameter int SYNC_STAGES = BHH_SYNC_DEFAULT
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_req_n,
  input  logic hold_en,
  input  logic bus_idle,
  input  logic cyc_pending,
  output logic hold_ack_n,
  output logic bus_req_n,
  output logic bus_float
);

  logic hold_req_sync_n;
  logic hold_seen;
  logic in_held;
  logic stay_held;
  logic float_w;
  logic req_active;

  bhh_sync #(
    .STAGES    (SYNC_STAGES),
    .RESET_VAL (1'b1)
  ) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (hold_req_n),
    .sync_out (hold_req_sync_n)
  );

  assign hold_seen = ~hold_req_sync_n;

  bhh_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold_seen (hold_seen),
    .hold_en   (hold_en),
    .bus_idle  (bus_idle),
    .in_held   (in_held),
    .stay_held (stay_held),
    .float_o   (float_w)
  );

  bhh_req_latch u_req (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_held     (in_held),
    .stay_held   (stay_held),
    .cyc_pending (cyc_pending),
    .req_active  (req_active)
  );

  assign hold_ack_n = ~in_held;
  assign bus_req_n  = ~req_active;
  assign bus_float  = float_w;

endmodule

// File: rtl/bus_hold_ctrl_chk.sv
module bus_hold_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic hold_en,
  input logic bus_idle,
  input logic cyc_pending,
  input logic hold_seen,
  input logic hold_ack_n,
  input logic bus_req_n,
  input logic bus_float
);

  // R5
  breq_needs_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req_n |-> !hold_ack_n);

  // R4
  ack_floats_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_ack_n |-> bus_float);

  // R4
  grant_on_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_ack_n) |-> $past(bus_idle) && $past(hold_seen));

  // R3
  grant_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_ack_n) |-> $past(hold_en));

  // R6
  breq_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_req_n) |-> cyc_pending);

  // R7
  breq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_req_n && hold_seen && hold_en) |=> !bus_req_n);

  // R8
  float_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_ack_n) |-> bus_float ##1 !bus_float);

  // R8
  release_together_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_ack_n) |-> bus_req_n);

endmodule

bind bus_hold_ctrl bus_hold_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .hold_en     (hold_en),
  .bus_idle    (bus_idle),
  .cyc_pending (cyc_pending),
  .hold_seen   (hold_seen),
  .hold_ack_n  (hold_ack_n),
  .bus_req_n   (bus_req_n),
  .bus_float   (bus_float)
);

// File: tb/bus_hold_ctrl_bench.sv
module bus_hold_ctrl_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hold_req_n = 1'b1;
  logic hold_en = 1'b0;
  logic bus_idle = 1'b0;
  logic cyc_pending = 1'b0;
  logic hold_ack_n, bus_req_n, bus_float;

  int vectors = 0;
  int miscompares = 0;
  bit checking = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bus_hold_ctrl u_bus_hold_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .hold_req_n  (hold_req_n),
    .hold_en     (hold_en),
    .bus_idle    (bus_idle),
    .cyc_pending (cyc_pending),
    .hold_ack_n  (hold_ack_n),
    .bus_req_n   (bus_req_n),
    .bus_float   (bus_float)
  );

  // Behavioural reference: request history queue plus a phase number
  // (0 released, 1 waiting for idle, 2 held, 3 floating tail).
  bit req_hist[$] = '{1'b1, 1'b1};
  int phase = 0;
  bit pend_seen = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      req_hist = '{1'b1, 1'b1};
      phase = 0;
      pend_seen = 1'b0;
    end else begin
      bit want;
      int nxt;
      want = (req_hist[0] == 1'b0) && hold_en;
      nxt = phase;
      if (phase == 0 && want) nxt = 1;
      else if (phase == 1) nxt = !want ? 0 : (bus_idle ? 2 : 1);
      else if (phase == 2 && !want) nxt = 3;
      else if (phase == 3) nxt = 0;
      pend_seen = (phase == 2 && nxt == 2) ? (pend_seen | cyc_pending) : 1'b0;
      phase = nxt;
      void'(req_hist.pop_front());
      req_hist.push_back(hold_req_n);
    end
  end

  task automatic check_bit(string req, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (checking) begin
      check_bit("R2 R3 R4 R10 hold_ack_n", hold_ack_n, !(phase == 2));
      check_bit("R5 R6 R7 bus_req_n", bus_req_n, !(phase == 2 && (pend_seen || cyc_pending)));
      check_bit("R8 R9 bus_float", bus_float, (phase == 2 || phase == 3));
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  initial begin
    #200000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    tick(1);
    // R1: outputs idle while reset is held
    check_bit("R1 hold_ack_n", hold_ack_n, 1'b1);
    check_bit("R1 bus_req_n", bus_req_n, 1'b1);
    check_bit("R1 bus_float", bus_float, 1'b0);
    checking = 1'b1;
    tick(2);
    rst_n = 1'b1;
    tick(2);

    // R3: request ignored while disabled
    hold_req_n = 1'b0; bus_idle = 1'b1; cyc_pending = 1'b1;
    tick(8);
    check_bit("R3 no ack when disabled", hold_ack_n, 1'b1);
    hold_req_n = 1'b1; cyc_pending = 1'b0;
    tick(3);

    // R2 R4: grant waits for idle, latency through synchroniser
    hold_en = 1'b1; bus_idle = 1'b0;
    hold_req_n = 1'b0;
    tick(6);
    check_bit("R4 no grant while busy", hold_ack_n, 1'b1);
    bus_idle = 1'b1;
    tick(1);
    check_bit("R4 grant on idle edge", hold_ack_n, 1'b0);
    check_bit("R4 float with grant", bus_float, 1'b1);

    // R6 R7: no request until pending, then one-cycle pulse is latched
    tick(3);
    check_bit("R6 no request without pending", bus_req_n, 1'b1);
    cyc_pending = 1'b1;
    tick(1);
    cyc_pending = 1'b0;
    tick(4);
    check_bit("R7 request held after pending drop", bus_req_n, 1'b0);

    // R8: withdraw hold, ack and request clear, float lingers one cycle
    hold_req_n = 1'b1;
    tick(8);
    check_bit("R8 float released", bus_float, 1'b0);

    // R5 R6: pending before grant, request comes with ack
    cyc_pending = 1'b1; bus_idle = 1'b0;
    hold_req_n = 1'b0;
    tick(5);
    bus_idle = 1'b1;
    tick(1);
    check_bit("R5 request with ack", bus_req_n, 1'b0);
    tick(3);

    // R9: enable drop while held
    hold_en = 1'b0;
    tick(1);
    check_bit("R9 ack cleared on disable", hold_ack_n, 1'b1);
    check_bit("R9 float tail", bus_float, 1'b1);
    tick(1);
    check_bit("R9 float cleared", bus_float, 1'b0);
    hold_req_n = 1'b1; cyc_pending = 1'b0;
    tick(4);

    // R10: withdraw before idle
    hold_en = 1'b1; bus_idle = 1'b0;
    hold_req_n = 1'b0;
    tick(5);
    hold_req_n = 1'b1;
    tick(3);
    bus_idle = 1'b1;
    tick(5);
    check_bit("R10 no ack after early withdraw", hold_ack_n, 1'b1);
    check_bit("R10 no float after early withdraw", bus_float, 1'b0);

    // R2: short glitch of hold request still synchronised, toggling idle
    hold_req_n = 1'b0;
    for (int k = 0; k < 12; k++) begin
      bus_idle = k[0];
      cyc_pending = k[1] & k[2];
      tick(1);
    end
    hold_req_n = 1'b1;
    tick(6);

    done = 1'b1;
    checking = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule